// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a clocked host and an external 8K x 8 asynchronous static RAM. The RAM has one active-low chip select, one active-high chip select, an active-low output enable, an active-low write enable, and one set of data pins that carries data in both directions. The host presents one request at a time through a valid/ready handshake. Each request carries an address, write data and a write flag. The block turns each request into a sequence of registered strobe levels. Every phase lasts a whole number of clock cycles, and each of those counts is a parameter.

A write first selects the chip and drives the data for a setup period. It then pulses write enable low for the pulse-width count. Write enable rises on the same edge that both chip selects go inactive and the data driver turns off. This uses the zero address-hold and zero data-hold the memory allows. A read keeps the data driver off and holds output enable and chip select active for the access count. Read data is sampled only at the end of the final cycle. A turnaround period then follows, so the memory has time to release the pins before the block drives them again. Completion is marked by a single-cycle done pulse.

The shared data pins appear on the block as three separate ports: a data output, a drive enable and a data input. The pad buffer outside the block combines them.

Top module: `async_sram_ctrl`

## Requirements
- R1: During and after a synchronous reset the block is idle. In the idle state the active-low chip select is 1, the active-high chip select is 0, output enable and write enable are both 1 (inactive), the data driver is off, ready is 1 and done is 0.
- R2: A request is taken on a clock edge where both valid and ready are high. Ready stays low for the whole of every access and every turnaround. The memory is never selected while ready is high.
- R3: In a write, both chip selects go active on the same edge as the address. The data driver stays on with write enable high for exactly DS_CYC cycles. Write enable is then low for exactly WP_CYC cycles, with the chip selected and the data driven throughout.
- R4: A write ends on a single edge. On that edge write enable returns to 1, both chip selects go inactive and the data driver turns off.
- R5: In a read, the data driver is off, and output enable and chip select are active together for exactly RD_CYC cycles. Read data is taken from the data input at the end of the last of those cycles.
- R6: After a read, ready stays low for exactly TA_CYC cycles, counted from the cycle in which done is high. The data driver never turns on within TA_CYC cycles of output enable going inactive.
- R7: Done is high for exactly one cycle per request. For a read, the returned data is valid in the done cycle and stays unchanged until the next read completes.
- R8: The 13-bit memory address is the request address. It is stable for every cycle in which the memory is selected.
- R9: The data driver is never on while output enable is low.
- R10: A value written to any address from 0 to 8191 is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last read data |
| mem_addr | output | 13 | Memory address pins |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_drive | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Data seen on the data pins |

## Verification
The bench uses a memory model that drives its pins only while it is selected with output enable low and write enable high. It drives unknown data until the read access count has elapsed, so sampling one cycle early returns bad data. The stimulus starts with writes to the two end addresses and to random addresses. These are followed by reads of the same addresses in reverse order, which separate address-path faults from data-path faults. Write-then-read pairs to the same address then exercise the read-to-write turnaround. Back-to-back reads show whether the turnaround is applied after every read. Every strobe width, setup count and gap is measured against the parameters, which are set away from their defaults.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_WSET = 3'd1,
        PH_WPUL = 3'd2,
        PH_RACC = 3'd3,
        PH_TURN = 3'd4
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic ce;
        logic oe_n;
        logic we_n;
        logic drv;
    } strobe_t;

    localparam strobe_t STB_QUIET = '{ce_n: 1'b1, ce: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

    // Strobe levels held for the whole of each phase.
    function automatic strobe_t strobes_for(phase_e ph);
        strobe_t s;
        s = STB_QUIET;
        case (ph)
            PH_WSET: begin
                s.ce_n = 1'b0;
                s.ce   = 1'b1;
                s.drv  = 1'b1;
            end
            PH_WPUL: begin
                s.ce_n = 1'b0;
                s.ce   = 1'b1;
                s.drv  = 1'b1;
                s.we_n = 1'b0;
            end
            PH_RACC: begin
                s.ce_n = 1'b0;
                s.ce   = 1'b1;
                s.oe_n = 1'b0;
            end
            default: s = STB_QUIET;
        endcase
        return s;
    endfunction

    function automatic int max_of4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (cap) hold_d = din;
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    assign dout = hold_q;

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int RD_CYC = 2,
    parameter int WP_CYC = 2,
    parameter int DS_CYC = 1,
    parameter int TA_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drive,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int MAX_CYC = max_of4(RD_CYC, WP_CYC, DS_CYC, TA_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] DS_LD = CNT_W'(DS_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ready;
        logic              done;
        strobe_t           stb;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        ph:    PH_IDLE,
        addr:  '0,
        wdata: '0,
        ready: 1'b1,
        done:  1'b0,
        stb:   STB_QUIET
    };

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             rd_cap;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk  (clk),
        .rst  (rst),
        .cap  (rd_cap),
        .din  (mem_dq_in),
        .dout (rsp_rdata)
    );

    // Next-state computation for every registered field.
    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        rd_cap   = 1'b0;

        case (ctl_q.ph)
            PH_IDLE: begin
                if (req_valid && ctl_q.ready) begin
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    tmr_load    = 1'b1;
                    if (req_we) begin
                        ctl_d.ph = PH_WSET;
                        tmr_val  = DS_LD;
                    end else begin
                        ctl_d.ph = PH_RACC;
                        tmr_val  = RD_LD;
                    end
                end
            end
            PH_WSET: begin
                if (tmr_expired) begin
                    ctl_d.ph = PH_WPUL;
                    tmr_load = 1'b1;
                    tmr_val  = WP_LD;
                end
            end
            PH_WPUL: begin
                if (tmr_expired) begin
                    ctl_d.ph   = PH_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            PH_RACC: begin
                if (tmr_expired) begin
                    ctl_d.ph   = PH_TURN;
                    ctl_d.done = 1'b1;
                    rd_cap     = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = TA_LD;
                end
            end
            PH_TURN: begin
                if (tmr_expired) ctl_d.ph = PH_IDLE;
            end
            default: ctl_d.ph = PH_IDLE;
        endcase

        ctl_d.ready = (ctl_d.ph == PH_IDLE);
        ctl_d.stb   = strobes_for(ctl_d.ph);
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RST;
        else     ctl_q <= ctl_d;
    end

    assign req_ready    = ctl_q.ready;
    assign rsp_done     = ctl_q.done;
    assign mem_addr     = ctl_q.addr;
    assign mem_ce_n     = ctl_q.stb.ce_n;
    assign mem_ce       = ctl_q.stb.ce;
    assign mem_oe_n     = ctl_q.stb.oe_n;
    assign mem_we_n     = ctl_q.stb.we_n;
    assign mem_dq_out   = ctl_q.wdata;
    assign mem_dq_drive = ctl_q.stb.drv;

    // Width and gap counters observed by the properties below.
    logic [CNT_W-1:0] we_lo_cnt, oe_lo_cnt, oe_hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_lo_cnt <= '0;
            oe_lo_cnt <= '0;
            oe_hi_cnt <= TA_LD + 1'b1;
        end else begin
            we_lo_cnt <= mem_we_n ? '0 : we_lo_cnt + 1'b1;
            oe_lo_cnt <= mem_oe_n ? '0 : oe_lo_cnt + 1'b1;
            if (!mem_oe_n)                           oe_hi_cnt <= '0;
            else if (oe_hi_cnt < CNT_W'(TA_CYC))     oe_hi_cnt <= oe_hi_cnt + 1'b1;
        end
    end

    AST_WE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_ce)); // R3
    AST_WE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_drive); // R3
    AST_WP_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_lo_cnt == CNT_W'(WP_CYC))); // R3
    AST_WRITE_END: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_ce_n && !mem_ce && !mem_dq_drive)); // R4
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n)); // R2
    AST_RD_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (oe_lo_cnt == CNT_W'(RD_CYC))); // R5
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_drive) |-> (oe_hi_cnt >= CNT_W'(TA_CYC))); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R8
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_drive); // R9

endmodule

// File: tb/async_sram_ctrl_bench.sv
module async_sram_ctrl_bench;

    localparam int RD = 3;
    localparam int WP = 2;
    localparam int DS = 2;
    localparam int TA = 2;

    typedef struct {
        bit         is_rd;
        int         addr;
        logic [7:0] data;
    } item_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_we;
    logic [12:0] req_addr;
    logic [7:0]  req_wdata;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic [12:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_drive;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int tests = 0;
    int fails = 0;

    item_t      sbq[$];
    logic [7:0] ref_mem [int];
    logic [7:0] model_mem [int];
    int         addr_list[$];

    always #4 clk = ~clk;

    async_sram_ctrl #(
        .RD_CYC(RD), .WP_CYC(WP), .DS_CYC(DS), .TA_CYC(TA)
    ) u_async_sram_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Memory model: drives only when selected, reading, and the access time has elapsed.
    initial begin
        int oe_run;
        oe_run = 0;
        mem_dq_in = 8'hzz;
        forever begin
            @(negedge clk);
            if (!mem_ce_n && mem_ce && mem_we_n && !mem_oe_n) begin
                oe_run++;
                if (oe_run >= RD && model_mem.exists(int'(mem_addr)))
                    mem_dq_in = model_mem[int'(mem_addr)];
                else
                    mem_dq_in = 8'hxx;
            end else begin
                oe_run = 0;
                mem_dq_in = 8'hzz;
            end
            if (!mem_ce_n && mem_ce && !mem_we_n) begin
                if (mem_dq_drive) model_mem[int'(mem_addr)] = mem_dq_out;
                else model_mem[int'(mem_addr)] = 8'hxx;
            end
        end
    end

    // Monitor: strobe timing and scoreboard.
    initial begin
        bit   p_we_n, p_oe_n, p_sel, p_drv, sel, addr_moved, rd_pend, have_rd;
        int   we_lo, oe_lo, oe_hi, setup, ready_lo;
        logic [12:0] p_addr;
        logic [7:0]  last_rd;
        item_t it;
        p_we_n = 1; p_oe_n = 1; p_sel = 0; p_drv = 0; addr_moved = 0;
        rd_pend = 0; have_rd = 0;
        we_lo = 0; oe_lo = 0; oe_hi = 1000; setup = 0; ready_lo = 0;
        p_addr = '0; last_rd = '0;
        forever begin
            @(negedge clk);
            if (rst) continue;
            sel = !mem_ce_n && mem_ce;

            if (mem_dq_drive || !mem_oe_n)
                chk(!(mem_dq_drive && !mem_oe_n), "R9 driver on with oe low", 1, 0);

            if (sel && !p_sel) begin
                chk(!req_ready, "R2 ready low while selected", req_ready, 0);
                if (sbq.size() > 0)
                    chk(mem_addr == sbq[0].addr[12:0], "R8 memory address", mem_addr, sbq[0].addr);
                addr_moved = 0;
            end
            if (sel && p_sel && mem_addr != p_addr) addr_moved = 1;
            if (!sel && p_sel) chk(!addr_moved, "R8 address stable while selected", addr_moved, 0);

            if (sel && mem_drv_setup()) setup++;
            if (!mem_we_n && p_we_n) begin
                chk(setup == DS, "R3 data setup cycles", setup, DS);
                chk(sel && mem_dq_drive, "R3 selected and driven at pulse", {sel, mem_dq_drive}, 3);
            end
            if (!sel) setup = 0;

            if (!mem_we_n) we_lo++;
            if (mem_we_n && !p_we_n) begin
                chk(we_lo == WP, "R3 write pulse width", we_lo, WP);
                chk(!sel && !mem_dq_drive, "R4 write end releases chip and bus",
                    {sel, mem_dq_drive}, 0);
                we_lo = 0;
            end

            if (!mem_oe_n) oe_lo++;
            if (mem_oe_n && !p_oe_n) begin
                chk(oe_lo == RD, "R5 output enable width", oe_lo, RD);
                chk(!sel, "R5 chip released with output enable", sel, 0);
                oe_lo = 0;
            end

            if (mem_drv_rise(p_drv)) chk(oe_hi > TA, "R6 turnaround before drive", oe_hi, TA + 1);
            if (mem_oe_n) oe_hi++; else oe_hi = 0;

            if (rd_pend) begin
                if (!req_ready) ready_lo++;
                else begin
                    chk(ready_lo == TA, "R6 ready low after read", ready_lo, TA);
                    rd_pend = 0;
                end
            end

            if (rsp_done) begin
                if (sbq.size() == 0) begin
                    chk(0, "R7 done with nothing pending", 1, 0);
                end else begin
                    it = sbq.pop_front();
                    if (it.is_rd) begin
                        chk(rsp_rdata === it.data, "R10 read data", rsp_rdata, it.data);
                        chk(!req_ready, "R2 ready low in read done cycle", req_ready, 0);
                        last_rd = rsp_rdata; have_rd = 1;
                        rd_pend = 1; ready_lo = 1;
                    end else begin
                        chk(model_mem.exists(it.addr) && model_mem[it.addr] === it.data,
                            "R10 stored write data",
                            model_mem.exists(it.addr) ? model_mem[it.addr] : -1, it.data);
                        if (have_rd)
                            chk(rsp_rdata === last_rd, "R7 read data held", rsp_rdata, last_rd);
                    end
                end
            end
            if (rsp_done && p_done_seen()) chk(0, "R7 done longer than one cycle", 2, 1);

            p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_sel = sel;
            p_drv = mem_dq_drive; p_addr = mem_addr;
        end
    end

    bit done_prev = 0;
    always @(negedge clk) done_prev <= rsp_done;

    function automatic bit p_done_seen();
        return done_prev;
    endfunction

    function automatic bit mem_drv_setup();
        return mem_dq_drive && mem_we_n;
    endfunction

    function automatic bit mem_drv_rise(input bit prev);
        return mem_dq_drive && !prev;
    endfunction

    // Driver: one outstanding request, expected item pushed at issue.
    task automatic issue(input bit we, input int a, input logic [7:0] d);
        item_t it;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a[12:0];
        req_wdata = d;
        it.is_rd  = !we;
        it.addr   = a;
        if (we) begin
            ref_mem[a] = d;
            it.data = d;
        end else begin
            it.data = ref_mem.exists(a) ? ref_mem[a] : 8'hxx;
        end
        sbq.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
    endtask

    initial begin
        int a;
        rst = 1'b1;
        req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (4) @(negedge clk);
        // R1: state held while reset is applied
        chk(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_drive,
            "R1 strobes quiet in reset",
            {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_drive}, 5'b10110);
        chk(req_ready && !rsp_done, "R1 ready high, done low", {req_ready, rsp_done}, 2'b10);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_drive && req_ready,
            "R1 idle after reset", {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_drive}, 5'b10110);

        // End addresses and random addresses
        addr_list.push_back(0);
        addr_list.push_back(8191);
        for (int i = 0; i < 60; i++) addr_list.push_back(int'($urandom_range(8191, 0)));
        foreach (addr_list[i]) issue(1'b1, addr_list[i], 8'($urandom));
        for (int i = addr_list.size() - 1; i >= 0; i--) issue(1'b0, addr_list[i], 8'h00);

        // Write-then-read pairs: exercises read-to-write turnaround
        for (int i = 0; i < 40; i++) begin
            a = int'($urandom_range(8191, 0));
            issue(1'b1, a, 8'($urandom));
            issue(1'b0, a, 8'h00);
        end
        // Back-to-back reads of the end addresses
        for (int i = 0; i < 4; i++) begin
            issue(1'b0, 0, 8'h00);
            issue(1'b0, 8191, 8'h00);
        end
        issue(1'b1, 8191, 8'hA5);
        issue(1'b0, 8191, 8'h00);

        repeat (8) @(negedge clk);
        chk(sbq.size() == 0, "R7 every request completed", sbq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog R2 run did not complete actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule